// File: doc/BRIEF.md
# Z80 I/O Bridge with Wait-State Stretching

This block sits on the I/O side of a Z80 bus and turns each port access into a request to one of three internal service endpoints: a boot-image byte source, a serial (UART) endpoint, and a storage endpoint. It samples IORQ, RD and WR on the system clock. The decode uses only the six low port address bits, so ports that differ only in bits 6 and 7 alias to the same service. The block pulls WAIT low from the first cycle of every I/O access. It keeps WAIT low until the selected endpoint acknowledges, so a slow back end sets the length of the CPU cycle.

For a write, the block latches the data byte and the six-bit port and sends a single-cycle strobe to the chosen endpoint. For a read, it latches the byte that the endpoint returns with its acknowledge. It then presents that byte with an output enable for the external bus pad, and holds it until IORQ rises. Memory cycles, with IORQ high, pass through untouched: no WAIT, no drive and no request. A read of the boot port after the image is used up returns a fixed fill byte and does not wait on any endpoint.

Top module: `z80_io_bridge`

## Requirements
- R1: While iorq_n is high, wait_n stays high, data_oe stays low and no request strobe is raised, whatever rd_n, wr_n, port_lo and data_in do.
- R2: Routing depends only on the six port bits. A read of port 6'h3F goes to the boot endpoint. Ports 6'h00 and 6'h01 go to the UART endpoint. Every other access, including a write to 6'h3F, goes to the storage endpoint. For example, CPU ports 8'hA8 and 8'h28 both reach storage as 6'h28, and 8'h81 reaches the UART as 6'h01.
- R3: wait_n goes low combinationally in the same cycle that iorq_n and either rd_n or wr_n are low, before any clock edge.
- R4: wait_n stays low until the clock edge at which the selected endpoint's ack is high. It is high from the cycle after that edge until iorq_n rises.
- R5: On the edge where an I/O write is first seen, the block latches data_in and port_lo. In the following cycle, and only then, the selected endpoint's request strobe is high, with req_write=1, req_port equal to the latched port and req_wdata equal to the latched byte.
- R6: For an I/O read, the strobe comes with req_write=0. The endpoint's read data, taken at its ack edge, appears on data_out from the next cycle and stays unchanged until iorq_n rises.
- R7: data_oe is high exactly when iorq_n and rd_n are both low. It is low during write cycles.
- R8: A read of 6'h3F while boot_end is low raises boot_req and returns boot_data from the boot_ack edge.
- R9: A read of 6'h3F while boot_end is high raises no strobe. It returns the fill byte 8'hFF, and wait_n is high from the cycle after the first edge of the access.
- R10: An ack from an endpoint that was not selected has no effect: wait_n stays low and the returned data is not taken.
- R11: After reset, with iorq_n high, wait_n is high, data_oe is low and all request strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iorq_n | input | 1 | CPU I/O request, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| port_lo | input | 6 | Low port address bits A0–A5 |
| data_in | input | 8 | Data bus as seen from the CPU side |
| data_out | output | 8 | Read data toward the bus pad |
| data_oe | output | 1 | Output enable for the data pad |
| wait_n | output | 1 | CPU WAIT, active low |
| boot_end | input | 1 | Boot image exhausted |
| boot_req | output | 1 | One-cycle request to boot source |
| boot_ack | input | 1 | Boot source done |
| boot_data | input | 8 | Next boot image byte |
| uart_req | output | 1 | One-cycle request to UART endpoint |
| uart_ack | input | 1 | UART endpoint done |
| uart_rdata | input | 8 | UART read byte |
| stor_req | output | 1 | One-cycle request to storage endpoint |
| stor_ack | input | 1 | Storage endpoint done |
| stor_rdata | input | 8 | Storage read byte |
| req_write | output | 1 | Latched direction, 1 for write |
| req_port | output | 6 | Latched port |
| req_wdata | output | 8 | Latched write byte |

## Verification
Two events can land on the same clock edge. One is the ack of the selected endpoint. The other is a stray ack from a different endpoint, either alone in an earlier cycle or together with the real ack. The bench raises such foreign acks at random during the wait period and on the acknowledge edge. It then checks that WAIT releases only on the real ack and that the read byte is the one the selected endpoint supplied. A second collision is the exhaustion flag being present on the capture edge of a boot read. That case must bypass the endpoint entirely, and the bench checks that no strobe appears.

// File: rtl/z80iob_pkg.sv
package z80iob_pkg;

    localparam int N_TGT = 3;

    typedef enum logic [1:0] {
        TGT_BOOT = 2'd0,
        TGT_UART = 2'd1,
        TGT_STOR = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_HOLD  = 2'd2
    } st_e;

endpackage

// File: rtl/z80iob_decode.sv
module z80iob_decode
    import z80iob_pkg::*;
#(
    parameter int          PORT_W        = 6,
    parameter logic [5:0]  BOOT_PORT     = 6'h3F,
    parameter logic [5:0]  UART_BASE     = 6'h00,
    parameter int          UART_SPAN_LOG2 = 1
) (
    input  logic [PORT_W-1:0] port,
    input  logic              is_read,
    output tgt_e              tgt
);

    localparam int HI_W = PORT_W - UART_SPAN_LOG2;

    logic [HI_W-1:0] port_hi;
    logic [HI_W-1:0] uart_hi;

    assign port_hi = port[PORT_W-1:UART_SPAN_LOG2];
    assign uart_hi = UART_BASE[PORT_W-1:UART_SPAN_LOG2];

    always_comb begin
        if (is_read && port == BOOT_PORT[PORT_W-1:0]) begin
            tgt = TGT_BOOT;
        end else if (port_hi == uart_hi) begin
            tgt = TGT_UART;
        end else begin
            tgt = TGT_STOR;
        end
    end

endmodule

// File: rtl/z80iob_ctrl.sv
module z80iob_ctrl
    import z80iob_pkg::*;
#(
    parameter int         PORT_W    = 6,
    parameter int         DATA_W    = 8,
    parameter logic [7:0] FILL_BYTE = 8'hFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    io_active,
    input  logic                    iorq_n,
    input  logic                    wr_n,
    input  logic [PORT_W-1:0]       port_lo,
    input  logic [DATA_W-1:0]       data_in,
    input  tgt_e                    tgt_in,
    input  logic                    boot_end,
    input  logic [N_TGT-1:0]        acks,
    input  logic [N_TGT-1:0][DATA_W-1:0] rdatas,
    output logic [N_TGT-1:0]        reqs,
    output logic                    busy,
    output logic                    ack_sel,
    output logic                    done,
    output logic                    req_write,
    output logic [PORT_W-1:0]       req_port,
    output logic [DATA_W-1:0]       req_wdata,
    output logic [DATA_W-1:0]       rdata
);

    typedef struct packed {
        st_e                st;
        tgt_e               tgt;
        logic               write;
        logic [PORT_W-1:0]  port;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic [N_TGT-1:0]   reqs;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic sel_ack;
    assign sel_ack = acks[r_q.tgt];

    always_comb begin
        r_d      = r_q;
        r_d.reqs = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (io_active) begin
                    r_d.port  = port_lo;
                    r_d.write = ~wr_n;
                    r_d.tgt   = tgt_in;
                    if (!wr_n) begin
                        r_d.wdata = data_in;
                    end
                    if (tgt_in == TGT_BOOT && boot_end) begin
                        r_d.rdata = FILL_BYTE[DATA_W-1:0];
                        r_d.st    = ST_HOLD;
                    end else begin
                        r_d.reqs[tgt_in] = 1'b1;
                        r_d.st           = ST_SERVE;
                    end
                end
            end
            ST_SERVE: begin
                if (sel_ack) begin
                    if (!r_q.write) begin
                        r_d.rdata = rdatas[r_q.tgt];
                    end
                    r_d.st = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (iorq_n) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, tgt: TGT_STOR, write: 1'b0,
                     port: '0, wdata: '0, rdata: '0, reqs: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign reqs      = r_q.reqs;
    assign busy      = (r_q.st == ST_SERVE);
    assign ack_sel   = sel_ack;
    assign done      = (r_q.st == ST_HOLD);
    assign req_write = r_q.write;
    assign req_port  = r_q.port;
    assign req_wdata = r_q.wdata;
    assign rdata     = r_q.rdata;

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs));
    assert_strobe_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reqs != '0) |=> (reqs == '0));
    assert_write_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((reqs != '0) && req_write) |-> (req_wdata == $past(data_in) && req_port == $past(port_lo)));
    assert_no_boot_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reqs[TGT_BOOT] |-> !$past(boot_end));

endmodule

// File: rtl/z80iob_bus.sv
module z80iob_bus #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              io_active,
    input  logic              done,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              wait_n
);

    assign wait_n   = ~(io_active & ~done);
    assign data_oe  = ~iorq_n & ~rd_n;
    assign data_out = rdata;

    assert_read_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_n && data_oe && $past(wait_n && data_oe)) |-> $stable(data_out));

endmodule

// File: rtl/z80_io_bridge.sv
module z80_io_bridge
    import z80iob_pkg::*;
#(
    parameter int         PORT_W         = 6,
    parameter int         DATA_W         = 8,
    parameter logic [5:0] BOOT_PORT      = 6'h3F,
    parameter logic [5:0] UART_BASE      = 6'h00,
    parameter int         UART_SPAN_LOG2 = 1,
    parameter logic [7:0] FILL_BYTE      = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [PORT_W-1:0] port_lo,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              wait_n,
    input  logic              boot_end,
    output logic              boot_req,
    input  logic              boot_ack,
    input  logic [DATA_W-1:0] boot_data,
    output logic              uart_req,
    input  logic              uart_ack,
    input  logic [DATA_W-1:0] uart_rdata,
    output logic              stor_req,
    input  logic              stor_ack,
    input  logic [DATA_W-1:0] stor_rdata,
    output logic              req_write,
    output logic [PORT_W-1:0] req_port,
    output logic [DATA_W-1:0] req_wdata
);

    logic                         io_active;
    tgt_e                         tgt;
    logic [N_TGT-1:0]             acks;
    logic [N_TGT-1:0][DATA_W-1:0] rdatas;
    logic [N_TGT-1:0]             reqs;
    logic                         busy, ack_sel, done;
    logic [DATA_W-1:0]            rdata;

    assign io_active = ~iorq_n & (~rd_n | ~wr_n);

    assign acks   = {stor_ack, uart_ack, boot_ack};
    assign rdatas = {stor_rdata, uart_rdata, boot_data};
    assign boot_req = reqs[TGT_BOOT];
    assign uart_req = reqs[TGT_UART];
    assign stor_req = reqs[TGT_STOR];

    z80iob_decode #(
        .PORT_W(PORT_W), .BOOT_PORT(BOOT_PORT),
        .UART_BASE(UART_BASE), .UART_SPAN_LOG2(UART_SPAN_LOG2)
    ) i_decode (
        .port(port_lo), .is_read(~rd_n), .tgt(tgt)
    );

    z80iob_ctrl #(
        .PORT_W(PORT_W), .DATA_W(DATA_W), .FILL_BYTE(FILL_BYTE)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .io_active(io_active), .iorq_n(iorq_n),
        .wr_n(wr_n), .port_lo(port_lo), .data_in(data_in), .tgt_in(tgt),
        .boot_end(boot_end), .acks(acks), .rdatas(rdatas), .reqs(reqs),
        .busy(busy), .ack_sel(ack_sel), .done(done), .req_write(req_write),
        .req_port(req_port), .req_wdata(req_wdata), .rdata(rdata)
    );

    z80iob_bus #(.DATA_W(DATA_W)) i_bus (
        .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .io_active(io_active), .done(done), .rdata(rdata),
        .data_out(data_out), .data_oe(data_oe), .wait_n(wait_n)
    );

    assert_memory_untouched_R1: assert property (@(posedge clk) disable iff (!rst_n)
        iorq_n |-> (wait_n && !data_oe && reqs == '0));
    assert_release_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack_sel && !iorq_n) |=> wait_n);
    assert_hold_without_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack_sel && !iorq_n) |=> !wait_n);

endmodule

// File: tb/test_z80_io_bridge.sv
module test_z80_io_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       iorq_n, rd_n, wr_n;
    logic [5:0] port_lo;
    logic [7:0] data_in, data_out;
    logic       data_oe, wait_n;
    logic       boot_end, boot_req, boot_ack;
    logic [7:0] boot_data;
    logic       uart_req, uart_ack;
    logic [7:0] uart_rdata;
    logic       stor_req, stor_ack;
    logic [7:0] stor_rdata;
    logic       req_write;
    logic [5:0] req_port;
    logic [7:0] req_wdata;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    z80_io_bridge i_z80_io_bridge (
        .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .port_lo(port_lo), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .wait_n(wait_n), .boot_end(boot_end),
        .boot_req(boot_req), .boot_ack(boot_ack), .boot_data(boot_data),
        .uart_req(uart_req), .uart_ack(uart_ack), .uart_rdata(uart_rdata),
        .stor_req(stor_req), .stor_ack(stor_ack), .stor_rdata(stor_rdata),
        .req_write(req_write), .req_port(req_port), .req_wdata(req_wdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // 0 boot, 1 uart, 2 storage, 3 exhausted boot read (fill)
    function automatic int expect_target(input logic [7:0] a, input bit rd, input bit bend);
        logic [5:0] lo;
        lo = a[5:0];
        if (rd && lo == 6'h3F) return bend ? 3 : 0;
        if (lo[5:1] == 5'b00000) return 1;
        return 2;
    endfunction

    function automatic logic [2:0] strobe_vec(input int t);
        case (t)
            0: return 3'b001;
            1: return 3'b010;
            2: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic drive_ack(input int t, input bit v, input logic [7:0] d);
        case (t)
            0: begin boot_ack = v; boot_data  = d; end
            1: begin uart_ack = v; uart_rdata = d; end
            default: begin stor_ack = v; stor_rdata = d; end
        endcase
    endtask

    task automatic mem_cycle(input logic [7:0] a, input logic [7:0] d, input bit rd);
        port_lo = a[5:0]; data_in = d; iorq_n = 1'b1;
        rd_n = ~rd; wr_n = rd;
        for (int k = 0; k < 2; k++) begin
            #1;
            check(wait_n == 1'b1, "R1 wait_n", wait_n, 1);
            check(data_oe == 1'b0, "R1 data_oe", data_oe, 0);
            check({stor_req, uart_req, boot_req} == 3'b000, "R1 strobes",
                  {stor_req, uart_req, boot_req}, 0);
            step();
        end
        rd_n = 1'b1; wr_n = 1'b1;
        step();
    endtask

    task automatic io_cycle(input logic [7:0] a, input bit rd, input logic [7:0] wd,
                            input int delay, input bit stray, input bit bend,
                            input logic [7:0] rv);
        int t;
        int f;
        t = expect_target(a, rd, bend);
        boot_end = bend; port_lo = a[5:0]; data_in = wd;
        iorq_n = 1'b0;
        if (rd) rd_n = 1'b0; else wr_n = 1'b0;
        #1;
        check(wait_n == 1'b0, "R3 wait asserted", wait_n, 0);
        check(data_oe == rd, "R7 oe follows rd", data_oe, int'(rd));
        step();
        if (t == 3) begin
            check({stor_req, uart_req, boot_req} == 3'b000, "R9 no strobe",
                  {stor_req, uart_req, boot_req}, 0);
            check(wait_n == 1'b1, "R9 no stall", wait_n, 1);
            check(data_out == 8'hFF, "R9 fill byte", data_out, 8'hFF);
        end else begin
            check({stor_req, uart_req, boot_req} == strobe_vec(t), "R2 R8 routing",
                  {stor_req, uart_req, boot_req}, strobe_vec(t));
            check(req_write == !rd, "R5 R6 direction", req_write, int'(!rd));
            check(req_port == a[5:0], "R2 R5 port", req_port, a[5:0]);
            if (!rd) check(req_wdata == wd, "R5 write data", req_wdata, wd);
            f = (t + 1) % 3;
            for (int k = 0; k < delay; k++) begin
                if (stray) drive_ack(f, 1'b1, 8'hEE);
                step();
                drive_ack(f, 1'b0, 8'h00);
                check(wait_n == 1'b0, "R4 R10 wait held", wait_n, 0);
                check({stor_req, uart_req, boot_req} == 3'b000, "R5 strobe one cycle",
                      {stor_req, uart_req, boot_req}, 0);
            end
            if (stray) drive_ack(f, 1'b1, 8'hEE);
            drive_ack(t, 1'b1, rv);
            step();
            drive_ack(t, 1'b0, 8'h00);
            drive_ack(f, 1'b0, 8'h00);
            check(wait_n == 1'b1, "R4 release after ack", wait_n, 1);
            check({stor_req, uart_req, boot_req} == 3'b000, "R5 strobe one cycle",
                  {stor_req, uart_req, boot_req}, 0);
            if (rd) check(data_out == rv, "R6 R10 read data", data_out, rv);
        end
        for (int k = 0; k < 2; k++) begin
            step();
            check(wait_n == 1'b1, "R4 wait stays released", wait_n, 1);
            if (rd) begin
                check(data_oe == 1'b1, "R7 oe during read", data_oe, 1);
                check(data_out == (t == 3 ? 8'hFF : rv), "R6 stable data", data_out,
                      (t == 3 ? 8'hFF : rv));
            end else begin
                check(data_oe == 1'b0, "R7 no drive on write", data_oe, 0);
            end
        end
        iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        #1;
        check(data_oe == 1'b0, "R7 oe off", data_oe, 0);
        step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, d, r;
        void'($urandom(32'd5150));
        rst_n = 1'b0; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        port_lo = '0; data_in = '0; boot_end = 1'b0;
        boot_ack = 0; uart_ack = 0; stor_ack = 0;
        boot_data = 0; uart_rdata = 0; stor_rdata = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(wait_n == 1'b1, "R11 reset wait", wait_n, 1);
        check(data_oe == 1'b0, "R11 reset oe", data_oe, 0);
        check({stor_req, uart_req, boot_req} == 3'b000, "R11 reset strobes",
              {stor_req, uart_req, boot_req}, 0);

        // directed corners
        mem_cycle(8'h12, 8'h34, 1'b1);
        mem_cycle(8'hFF, 8'h56, 1'b0);
        io_cycle(8'hA8, 1'b0, 8'h5A, 1, 1'b0, 1'b0, 8'h00);   // R2 alias
        io_cycle(8'h28, 1'b1, 8'h00, 0, 1'b0, 1'b0, 8'h3C);   // R2 alias
        io_cycle(8'h81, 1'b0, 8'h41, 2, 1'b1, 1'b0, 8'h00);   // UART tx, stray R10
        io_cycle(8'h80, 1'b1, 8'h00, 3, 1'b1, 1'b0, 8'h99);   // UART rx, stray R10
        io_cycle(8'hFF, 1'b1, 8'h00, 2, 1'b0, 1'b0, 8'hC3);   // R8 boot
        io_cycle(8'hFF, 1'b0, 8'h77, 0, 1'b0, 1'b0, 8'h00);   // write to boot port -> storage
        io_cycle(8'hFF, 1'b1, 8'h00, 0, 1'b0, 1'b1, 8'h00);   // R9 fill
        io_cycle(8'h3F, 1'b1, 8'h00, 0, 1'b1, 1'b0, 8'h18);   // same-edge foreign ack

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            a = 8'($urandom);
            d = 8'($urandom);
            r = 8'($urandom);
            if ($urandom % 4 == 0) a = {a[7:6], 6'h3F};
            else if ($urandom % 4 == 0) a = {a[7:6], 5'b00000, a[0]};
            if ($urandom % 6 == 0) mem_cycle(a, d, 1'($urandom));
            else io_cycle(a, 1'($urandom), d, int'($urandom % 4), 1'($urandom),
                          ($urandom % 5 == 0), r);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule